// File: doc/BRIEF.md
# Compare-Match PWM Timer Channel

This block is one timer channel. It has a 16-bit up-counter and four compare registers, named A, B, C and D. Two PWM pins are built from compare-match events: pin A and pin C. Each compare register carries a 2-bit action code. When the counter equals the register value, the action code sets what happens to the pin that register serves. Each pin also has an initial-level bit. The pin loads that level whenever the channel restarts.

The channel has two modes:

- **Paired mode.** The counter runs freely and wraps, so the PWM period is the counter overflow time. Registers A and B shape pin A. Registers C and D shape pin C. Placing the two pairs' edges at different counts gives two phase-shifted outputs.
- **Cycle/duty mode.** One selected register is the period register. A match on it clears the counter and returns both pins to their initial levels. The remaining registers act as duty thresholds on the same pins as in paired mode.

All settings are loaded through a simple synchronous write port. The port takes one write per clock cycle. Every write takes effect at the next clock edge. There is no back-pressure: the port is always ready, so a write is accepted in the cycle `wr_en` is high.

Top module: `cmpwm_timer`

## Requirements
- R1: The write port decodes `wr_addr` as follows. Addresses 0 to 3 load compare registers A, B, C and D. Address 4 loads the action codes: bits [1:0] for A, [3:2] for B, [5:4] for C and [7:6] for D. Address 4 also loads the initial levels: bit 8 for pin A and bit 9 for pin C. Address 5 is control: bit 0 enable, bit 1 mode (0 paired, 1 cycle/duty) and bits [3:2] period-register select (0=A … 3=D). A written compare value applies to matches from the next clock edge on, including while the counter is running.
- R2: The action codes are 00 hold, 01 drive low, 10 drive high and 11 toggle. A code is applied to the pin at the clock edge where the counter equals its register.
- R3: Pin A responds only to registers A and B, and pin C responds only to registers C and D. In paired mode this gives two independent outputs, whose edges may sit at different counts.
- R4: In paired mode, if the two registers of a pair hold equal values, a match on them leaves that pin unchanged.
- R5: In paired mode, no compare register clears the counter. The counter counts up by one per enabled cycle and wraps from 0xFFFF to 0.
- R6: While enable is 0, the counter holds its value and no match changes a pin.
- R7: In cycle/duty mode, a match on the selected period register clears the counter to 0 at that edge, instead of incrementing it. The period register's own action code is not used.
- R8: At a period clear, both pins load their initial-level bits. A duty register whose value equals the period value has no effect: the pin still ends at its initial level.
- R9: If both registers serving one pin match in the same cycle and their action is not suppressed, the action of the second register (B or D) decides the pin.
- R10: A control write that changes the mode bit clears the counter to 0 and loads both pins with their initial levels, at that same edge.
- R11: After reset, the counter is 0, both pins are 0 and all settings are 0 (paired mode, disabled).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 3 | Setting address |
| wr_data | input | 16 | Write data |
| count_o | output | 16 | Current counter value |
| pwm_a_o | output | 1 | PWM pin A |
| pwm_c_o | output | 1 | PWM pin C |

## Verification
The hardest situation to reach from the ports is the paired-mode wrap. To observe it, the bench lets the counter run through all 65536 states with both pairs active, and confirms that the pins repeat their pattern after 0xFFFF. Coincident matches cannot be forced directly. The bench reaches them by programming two registers of one pair to the same count, in both modes, so that suppression (R4) and second-register priority (R9) become visible. A further case sets a duty register equal to the period value, with an action that disagrees with the initial level. That makes the order of clear and duty action observable at the pin.

// File: rtl/cmpwm_pkg.sv
package cmpwm_pkg;

  localparam int CMP_N  = 4;
  localparam int PIN_N  = 2;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_LVL  = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd5;

  typedef enum logic [1:0] {
    ACT_HOLD   = 2'b00,
    ACT_LOW    = 2'b01,
    ACT_HIGH   = 2'b10,
    ACT_TOGGLE = 2'b11
  } act_code_e;

  function automatic logic act_apply(input logic cur, input logic [1:0] code);
    logic res;
    case (act_code_e'(code))
      ACT_LOW:    res = 1'b0;
      ACT_HIGH:   res = 1'b1;
      ACT_TOGGLE: res = ~cur;
      default:    res = cur;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/cmpwm_regs.sv
module cmpwm_regs
  import cmpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [CNT_W-1:0]            wr_data,
  output logic [CMP_N-1:0][CNT_W-1:0] cmp_val,
  output logic [CMP_N-1:0][1:0]       act_code,
  output logic [PIN_N-1:0]            init_lvl,
  output logic                        run_en,
  output logic                        mode_cd,
  output logic [1:0]                  period_sel,
  output logic                        mode_chg
);

  localparam int CMP_SEL_W = $clog2(CMP_N);

  logic ctrl_wr;

  assign ctrl_wr  = wr_en && (wr_addr == ADDR_CTRL);
  assign mode_chg = ctrl_wr && (wr_data[1] != mode_cd);

  // compare registers: addresses 0 .. CMP_N-1
  for (genvar gi = 0; gi < CMP_N; gi++) begin : g_cmp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cmp_val[gi] <= '0;
      end else if (wr_en && (wr_addr == ADDR_W'(gi))) begin
        cmp_val[gi] <= wr_data;
      end
    end
  end

  // action codes and initial levels share one address
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_code <= '0;
      init_lvl <= '0;
    end else if (wr_en && (wr_addr == ADDR_LVL)) begin
      for (int k = 0; k < CMP_N; k++) begin
        act_code[k] <= wr_data[2*k +: 2];
      end
      init_lvl <= wr_data[2*CMP_N +: PIN_N];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_en     <= 1'b0;
      mode_cd    <= 1'b0;
      period_sel <= '0;
    end else if (ctrl_wr) begin
      run_en     <= wr_data[0];
      mode_cd    <= wr_data[1];
      period_sel <= wr_data[2 +: CMP_SEL_W];
    end
  end

endmodule

// File: rtl/cmpwm_counter.sv
module cmpwm_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             mode_clr,
  input  logic             period_clr,
  output logic [CNT_W-1:0] count
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (mode_clr) begin
      count <= '0;
    end else if (run_en) begin
      if (period_clr) begin
        count <= '0;
      end else begin
        count <= count + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/cmpwm_match.sv
module cmpwm_match
  import cmpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                        run_en,
  input  logic                        mode_cd,
  input  logic [1:0]                  period_sel,
  input  logic [CNT_W-1:0]            count,
  input  logic [CMP_N-1:0][CNT_W-1:0] cmp_val,
  output logic [CMP_N-1:0]            act_fire,
  output logic                        period_hit
);

  logic [CNT_W-1:0] period_val;
  logic [CMP_N-1:0] hit;
  logic [CMP_N-1:0] pair_eq;
  logic [CMP_N-1:0] per_eq;
  logic [CMP_N-1:0] is_per;

  assign period_val = cmp_val[period_sel];
  assign period_hit = mode_cd && run_en && (count == period_val);

  for (genvar gi = 0; gi < CMP_N; gi++) begin : g_cmp
    localparam int PARTNER = gi ^ 1;
    assign hit[gi]     = run_en && (count == cmp_val[gi]);
    assign pair_eq[gi] = (cmp_val[gi] == cmp_val[PARTNER]);
    assign per_eq[gi]  = (cmp_val[gi] == period_val);
    assign is_per[gi]  = (period_sel == 2'(gi));
    assign act_fire[gi] = hit[gi] &&
                          (mode_cd ? !(is_per[gi] || per_eq[gi]) : !pair_eq[gi]);
  end

endmodule

// File: rtl/cmpwm_pin.sv
module cmpwm_pin
  import cmpwm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reload,
  input  logic       init_bit,
  input  logic       first_fire,
  input  logic [1:0] first_code,
  input  logic       second_fire,
  input  logic [1:0] second_code,
  output logic       pin_o
);

  logic pin_nxt;

  always_comb begin
    pin_nxt = pin_o;
    if (reload) begin
      pin_nxt = init_bit;
    end else if (second_fire) begin
      pin_nxt = act_apply(pin_o, second_code);
    end else if (first_fire) begin
      pin_nxt = act_apply(pin_o, first_code);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_o <= 1'b0;
    end else begin
      pin_o <= pin_nxt;
    end
  end

endmodule

// File: rtl/cmpwm_timer.sv
module cmpwm_timer
  import cmpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] count_o,
  output logic             pwm_a_o,
  output logic             pwm_c_o
);

  logic [CMP_N-1:0][CNT_W-1:0] cmp_val;
  logic [CMP_N-1:0][1:0]       act_code;
  logic [PIN_N-1:0]            init_lvl;
  logic                        run_en;
  logic                        mode_cd;
  logic [1:0]                  period_sel;
  logic                        mode_chg;
  logic [CMP_N-1:0]            act_fire;
  logic                        period_hit;
  logic [PIN_N-1:0]            pin_q;

  cmpwm_regs #(.CNT_W(CNT_W)) regs_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .cmp_val    (cmp_val),
    .act_code   (act_code),
    .init_lvl   (init_lvl),
    .run_en     (run_en),
    .mode_cd    (mode_cd),
    .period_sel (period_sel),
    .mode_chg   (mode_chg)
  );

  cmpwm_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_en     (run_en),
    .mode_clr   (mode_chg),
    .period_clr (period_hit),
    .count      (count_o)
  );

  cmpwm_match #(.CNT_W(CNT_W)) match_i (
    .run_en     (run_en),
    .mode_cd    (mode_cd),
    .period_sel (period_sel),
    .count      (count_o),
    .cmp_val    (cmp_val),
    .act_fire   (act_fire),
    .period_hit (period_hit)
  );

  for (genvar gp = 0; gp < PIN_N; gp++) begin : g_pin
    cmpwm_pin pin_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .reload      (mode_chg || period_hit),
      .init_bit    (init_lvl[gp]),
      .first_fire  (act_fire[2*gp]),
      .first_code  (act_code[2*gp]),
      .second_fire (act_fire[2*gp+1]),
      .second_code (act_code[2*gp+1]),
      .pin_o       (pin_q[gp])
    );
  end

  assign pwm_a_o = pin_q[0];
  assign pwm_c_o = pin_q[1];

endmodule

// File: rtl/cmpwm_timer_chk.sv
module cmpwm_timer_chk
  import cmpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        wr_en,
  input logic [2:0]                  wr_addr,
  input logic [CNT_W-1:0]            wr_data,
  input logic [CNT_W-1:0]            count_o,
  input logic                        pwm_a_o,
  input logic                        pwm_c_o,
  input logic                        run_en,
  input logic                        mode_cd,
  input logic [1:0]                  period_sel,
  input logic [CMP_N-1:0][CNT_W-1:0] cmp_val,
  input logic [PIN_N-1:0]            init_lvl
);

  logic ctrl_wr;
  assign ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);

  // R5
  free_run_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !mode_cd && !ctrl_wr) |=>
      (count_o == ($past(count_o) + CNT_W'(1))));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !ctrl_wr) |=> ($stable(count_o) && $stable(pwm_a_o) && $stable(pwm_c_o)));

  // R4
  equal_pair_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !mode_cd && !ctrl_wr && (cmp_val[0] == cmp_val[1]) && (count_o == cmp_val[0]))
      |=> $stable(pwm_a_o));

  // R7
  period_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && mode_cd && !ctrl_wr && (count_o == cmp_val[period_sel])) |=> (count_o == '0));

  // R8
  period_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && mode_cd && !ctrl_wr && (count_o == cmp_val[period_sel])) |=>
      ((pwm_a_o == $past(init_lvl[0])) && (pwm_c_o == $past(init_lvl[1]))));

  // R10
  mode_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && (wr_data[1] != mode_cd)) |=>
      ((count_o == '0) && (pwm_a_o == $past(init_lvl[0])) && (pwm_c_o == $past(init_lvl[1]))));

endmodule

bind cmpwm_timer cmpwm_timer_chk #(.CNT_W(CNT_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .count_o    (count_o),
  .pwm_a_o    (pwm_a_o),
  .pwm_c_o    (pwm_c_o),
  .run_en     (run_en),
  .mode_cd    (mode_cd),
  .period_sel (period_sel),
  .cmp_val    (cmp_val),
  .init_lvl   (init_lvl)
);

// File: tb/cmpwm_timer_tb_top.sv
module cmpwm_timer_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] count_o;
  logic        pwm_a_o;
  logic        pwm_c_o;

  int total = 0;
  int bad = 0;
  logic done = 1'b0;
  logic cur_mode = 1'b0;

  always #5 clk = ~clk;

  cmpwm_timer dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .count_o (count_o),
    .pwm_a_o (pwm_a_o),
    .pwm_c_o (pwm_c_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [15:0] ctrl(input logic en, input logic m, input logic [1:0] ps);
    return {12'd0, ps, m, en};
  endfunction

  // two mode flips: counter at 0, pins at their initial levels, disabled
  task automatic restart(input logic m, input logic [1:0] ps);
    wr(3'd5, ctrl(1'b0, ~m, ps));
    wr(3'd5, ctrl(1'b0, m, ps));
    cur_mode = m;
  endtask

  task automatic wait_count(input logic [15:0] v, input string tag);
    for (int n = 0; n < 70000; n++) begin
      if (count_o == v) return;
      @(negedge clk);
    end
    check({tag, " count not reached"}, count_o, v);
  endtask

  task automatic t_reset();
    check("R11 count", count_o, 0);
    check("R11 pin A", pwm_a_o, 0);
    check("R11 pin C", pwm_c_o, 0);
  endtask

  // A=10 high, B=20 low, C=15 toggle, D=40 toggle, init A=0 C=1
  task automatic t_paired_and_wrap();
    wr(3'd4, 16'd758);
    restart(1'b0, 2'd0);
    check("R10 init C on restart", pwm_c_o, 1);
    wr(3'd0, 16'd10); wr(3'd1, 16'd20); wr(3'd2, 16'd15); wr(3'd3, 16'd40);
    wr(3'd5, ctrl(1'b1, 1'b0, 2'd0));
    wait_count(16'd10, "R3");
    check("R3 pin A before A match", pwm_a_o, 0);
    check("R3 pin C before C match", pwm_c_o, 1);
    wait_count(16'd11, "R2");
    check("R2 high code on A", pwm_a_o, 1);
    wait_count(16'd16, "R2");
    check("R2 toggle code on C", pwm_c_o, 0);
    check("R3 pin A unaffected by C", pwm_a_o, 1);
    wait_count(16'd21, "R2");
    check("R2 low code on B", pwm_a_o, 0);
    wait_count(16'd41, "R3");
    check("R3 D toggles C back", pwm_c_o, 1);
    wait_count(16'd41, "R5");
    wait_count(16'hFFFF, "R5");
    @(negedge clk);
    check("R5 wrap to zero", count_o, 0);
    wait_count(16'd11, "R5");
    check("R5 pattern repeats after wrap", pwm_a_o, 1);
  endtask

  // A=B=12: A high, B toggle; init 0
  task automatic t_equal_pair_and_live_write();
    wr(3'd4, 16'd14);
    restart(1'b0, 2'd0);
    wr(3'd0, 16'd12); wr(3'd1, 16'd12); wr(3'd2, 16'd200); wr(3'd3, 16'd300);
    wr(3'd5, ctrl(1'b1, 1'b0, 2'd0));
    wait_count(16'd13, "R4");
    check("R4 equal pair leaves pin", pwm_a_o, 0);
    wr(3'd1, 16'd30);
    wait_count(16'd31, "R1");
    check("R1 live write of B used", pwm_a_o, 1);
  endtask

  task automatic t_disable();
    logic [15:0] held;
    logic pa;
    wr(3'd5, ctrl(1'b0, cur_mode, 2'd0));
    held = count_o;
    pa = pwm_a_o;
    // place B on the held count: a match would toggle pin A
    wr(3'd1, held);
    repeat (6) @(negedge clk);
    check("R6 count holds", count_o, held);
    check("R6 no match while off", pwm_a_o, pa);
  endtask

  task automatic t_mode_change();
    wr(3'd4, 16'd768);
    wr(3'd5, ctrl(1'b1, 1'b1, 2'd3));
    cur_mode = 1'b1;
    check("R10 count cleared", count_o, 0);
    check("R10 pin A reload", pwm_a_o, 1);
    check("R10 pin C reload", pwm_c_o, 1);
  endtask

  // period D=50 (code toggle, ignored); A=10 high, B=30 low, C=20 high
  task automatic t_cycle_duty();
    wr(3'd4, 16'd230);
    restart(1'b1, 2'd3);
    wr(3'd0, 16'd10); wr(3'd1, 16'd30); wr(3'd2, 16'd20); wr(3'd3, 16'd50);
    wr(3'd5, ctrl(1'b1, 1'b1, 2'd3));
    wait_count(16'd25, "R7");
    check("R2 duty A high", pwm_a_o, 1);
    check("R2 duty C high", pwm_c_o, 1);
    wait_count(16'd35, "R7");
    check("R2 duty B low", pwm_a_o, 0);
    wait_count(16'd50, "R7");
    @(negedge clk);
    check("R7 period clears count", count_o, 0);
    check("R8 pin A reload", pwm_a_o, 0);
    check("R8 pin C reload", pwm_c_o, 0);
    wait_count(16'd15, "R7");
    check("R7 next period runs", pwm_a_o, 1);
  endtask

  // period B=20; C=5 high, D=10 low
  task automatic t_period_select();
    wr(3'd4, 16'd96);
    restart(1'b1, 2'd1);
    wr(3'd0, 16'd300); wr(3'd1, 16'd20); wr(3'd2, 16'd5); wr(3'd3, 16'd10);
    wr(3'd5, ctrl(1'b1, 1'b1, 2'd1));
    wait_count(16'd7, "R7");
    check("R7 C high in short period", pwm_c_o, 1);
    wait_count(16'd20, "R7");
    @(negedge clk);
    check("R7 period B clears", count_o, 0);
  endtask

  // period D=50; A=10 toggle, B=50 low; init A=1
  task automatic t_duty_equals_period();
    wr(3'd4, 16'd263);
    restart(1'b1, 2'd3);
    wr(3'd0, 16'd10); wr(3'd1, 16'd50); wr(3'd2, 16'd400); wr(3'd3, 16'd50);
    wr(3'd5, ctrl(1'b1, 1'b1, 2'd3));
    check("R8 init A after restart", pwm_a_o, 1);
    wait_count(16'd11, "R8");
    check("R2 toggle in cycle mode", pwm_a_o, 0);
    wait_count(16'd50, "R8");
    @(negedge clk);
    check("R8 duty at period ignored", pwm_a_o, 1);
  endtask

  // period D=40; A=B=15: A high, B low; C=15 high; init A=1
  task automatic t_priority();
    wr(3'd4, 16'd294);
    restart(1'b1, 2'd3);
    wr(3'd0, 16'd15); wr(3'd1, 16'd15); wr(3'd2, 16'd15); wr(3'd3, 16'd40);
    wr(3'd5, ctrl(1'b1, 1'b1, 2'd3));
    wait_count(16'd16, "R9");
    check("R9 second register wins", pwm_a_o, 0);
    check("R9 C duty fires", pwm_c_o, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_paired_and_wrap();
    t_equal_pair_and_live_write();
    t_disable();
    t_mode_change();
    t_cycle_duty();
    t_period_select();
    t_duty_equals_period();
    t_priority();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule